// File: doc/BRIEF.md
# Stall and Flush Control for a Five-Stage Pipeline

This block decides, cycle by cycle, whether the front end of a five-stage in-order integer pipeline may advance, whether a bubble must enter the decode-to-execute register, and whether a branch resolved in decode redirects fetch. It looks only at register numbers and a few control flags from the decode, execute and memory stages. Every output is a combinational function of the present inputs. Whatever the surrounding pipeline shifts into its stage registers next cycle sets the following cycle's answer.

Two kinds of hazard are handled. The first is a value loaded from memory that the very next instruction reads. Because branches compare their operands in decode, a branch also has to wait for any result that cannot yet be forwarded to decode. That covers an ALU result still in execute, and a loaded value still in execute or in memory. A stall always overrides redirection. A branch only takes effect in a cycle when its operands are ready, and a taken branch squashes the instruction fetched behind it.

Top module: `hazard_ctl`

## Requirements
- R1: When the execute-stage instruction reads memory, its destination is nonzero, and that destination equals either decode source, the block sets `pc_we`=0, `ifid_we`=0 and `idex_bubble`=1.
- R2: With no hazard present, `pc_we`=1, `ifid_we`=1 and `idex_bubble`=0.
- R3: A destination register number of 0 never causes a stall, whatever the flags and source fields are.
- R4: A branch in decode (`id_branch`=1) stalls when either source equals the nonzero execute-stage destination and that instruction writes a register or reads memory. A non-branch instruction is not stalled by a non-load execute-stage writer.
- R5: A branch in decode stalls when either source equals the nonzero memory-stage destination of an instruction with both `exmem_mem_rd`=1 and `exmem_reg_wr`=1. A memory-stage ALU result (`exmem_mem_rd`=0) never stalls, and a non-branch is never stalled from the memory stage.
- R6: A branch is taken when `id_branch`=1 and (`id_regs_equal` XOR `id_br_ne`)=1. Here `id_br_ne`=0 selects branch-if-equal and 1 selects branch-if-not-equal. Without a stall, a taken branch drives `if_flush`=1 and `pc_sel_branch`=1.
- R7: With no branch, or with a branch that is not taken, `if_flush`=0 and `pc_sel_branch`=0.
- R8: In any stall cycle, `if_flush`=0 and `pc_sel_branch`=0.
- R9: `pc_we` and `ifid_we` are always equal, and both are the inverse of `idex_bubble`.
- R10: When a load is followed directly by a dependent branch, the stall lasts two cycles as the load moves from execute to memory. A load followed by a dependent non-branch stalls one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ifid_rs | input | AW | First source register of the decode instruction |
| ifid_rt | input | AW | Second source register of the decode instruction |
| idex_rd | input | AW | Destination register of the execute instruction |
| idex_mem_rd | input | 1 | Execute instruction reads memory |
| idex_reg_wr | input | 1 | Execute instruction writes a register |
| exmem_rd | input | AW | Destination register of the memory-stage instruction |
| exmem_mem_rd | input | 1 | Memory-stage instruction reads memory |
| exmem_reg_wr | input | 1 | Memory-stage instruction writes a register |
| id_branch | input | 1 | Decode instruction is a conditional branch |
| id_br_ne | input | 1 | Branch sense: 0 taken on equal, 1 taken on not equal |
| id_regs_equal | input | 1 | Decode-stage operand compare result |
| pc_we | output | 1 | Program counter may update |
| ifid_we | output | 1 | Fetch-to-decode register may update |
| idex_bubble | output | 1 | Zero the control bits entering execute |
| if_flush | output | 1 | Turn the just-fetched instruction into a no-op |
| pc_sel_branch | output | 1 | Select the branch target for the next PC |

## Verification
The hardest situation is a taken branch that collides with a pending operand, so that stall priority decides the outcome. This is hardest of all when the producer is a load that passes through two stages and holds the branch for two cycles in a row. Random stimulus draws register numbers from a very small range, including 0, so that source and destination matches happen often and collide with random branch flags. Directed sequences then move a load from execute to memory behind a dependent branch, and behind a dependent add, to show the two-cycle and one-cycle stall lengths.

// File: rtl/hz_pkg.sv
package hz_pkg;
    localparam int unsigned REG_AW = 5;

    typedef struct packed {
        logic pc_we;
        logic ifid_we;
        logic idex_bubble;
        logic if_flush;
        logic pc_sel_branch;
    } hz_ctl_t;
endpackage

// File: rtl/hz_dep_match.sv
module hz_dep_match #(
    parameter int unsigned AW = 5
) (
    input  logic [AW-1:0] dst,
    input  logic          dst_live,
    input  logic [AW-1:0] src_a,
    input  logic [AW-1:0] src_b,
    output logic          hit
);
    localparam logic [AW-1:0] ZERO_REG = '0;

    logic nz_d;
    logic eq_a_d;
    logic eq_b_d;

    always_comb begin
        nz_d   = (dst != ZERO_REG);
        eq_a_d = (dst == src_a);
        eq_b_d = (dst == src_b);
        hit    = dst_live && nz_d && (eq_a_d || eq_b_d);
    end

    always_comb begin
        if (!$isunknown({dst, dst_live}) && dst == ZERO_REG) begin
            a_r3_zero_never_hits: assert (!hit)
                else $error("register 0 destination produced a dependence");
        end
    end
endmodule

// File: rtl/hz_branch_resolve.sv
module hz_branch_resolve (
    input  logic is_branch,
    input  logic ne_sense,
    input  logic regs_equal,
    input  logic hold,
    output logic taken
);
    logic cond_d;

    always_comb begin
        cond_d = regs_equal ^ ne_sense;
        taken  = is_branch && cond_d && !hold;
    end

    always_comb begin
        if (!$isunknown({is_branch, hold}) && (!is_branch || hold)) begin
            a_r7_no_redirect_idle: assert (!taken)
                else $error("redirect without an active branch");
        end
    end
endmodule

// File: rtl/hazard_ctl.sv
module hazard_ctl #(
    parameter int unsigned AW = hz_pkg::REG_AW
) (
    input  logic [AW-1:0] ifid_rs,
    input  logic [AW-1:0] ifid_rt,
    input  logic [AW-1:0] idex_rd,
    input  logic          idex_mem_rd,
    input  logic          idex_reg_wr,
    input  logic [AW-1:0] exmem_rd,
    input  logic          exmem_mem_rd,
    input  logic          exmem_reg_wr,
    input  logic          id_branch,
    input  logic          id_br_ne,
    input  logic          id_regs_equal,
    output logic          pc_we,
    output logic          ifid_we,
    output logic          idex_bubble,
    output logic          if_flush,
    output logic          pc_sel_branch
);
    import hz_pkg::*;

    logic    load_use_hit;
    logic    br_ex_hit;
    logic    br_mem_hit;
    logic    ex_writer;
    logic    mem_loader;
    logic    stall_d;
    logic    taken;
    hz_ctl_t ctl_d;

    assign ex_writer  = idex_reg_wr | idex_mem_rd;
    assign mem_loader = exmem_mem_rd & exmem_reg_wr;

    // load in execute feeding any consumer in decode
    hz_dep_match #(.AW(AW)) u_load_use (
        .dst(idex_rd), .dst_live(idex_mem_rd),
        .src_a(ifid_rs), .src_b(ifid_rt), .hit(load_use_hit)
    );

    // any result in execute is too late for a decode-stage compare
    hz_dep_match #(.AW(AW)) u_br_ex (
        .dst(idex_rd), .dst_live(ex_writer & id_branch),
        .src_a(ifid_rs), .src_b(ifid_rt), .hit(br_ex_hit)
    );

    // load data still in the memory stage is too late as well
    hz_dep_match #(.AW(AW)) u_br_mem (
        .dst(exmem_rd), .dst_live(mem_loader & id_branch),
        .src_a(ifid_rs), .src_b(ifid_rt), .hit(br_mem_hit)
    );

    assign stall_d = load_use_hit | br_ex_hit | br_mem_hit;

    hz_branch_resolve u_resolve (
        .is_branch(id_branch), .ne_sense(id_br_ne),
        .regs_equal(id_regs_equal), .hold(stall_d), .taken(taken)
    );

    always_comb begin
        ctl_d               = '0;
        ctl_d.pc_we         = !stall_d;
        ctl_d.ifid_we       = !stall_d;
        ctl_d.idex_bubble   = stall_d;
        ctl_d.if_flush      = taken;
        ctl_d.pc_sel_branch = taken;
    end

    assign pc_we         = ctl_d.pc_we;
    assign ifid_we       = ctl_d.ifid_we;
    assign idex_bubble   = ctl_d.idex_bubble;
    assign if_flush      = ctl_d.if_flush;
    assign pc_sel_branch = ctl_d.pc_sel_branch;

    always_comb begin
        if (!$isunknown({ifid_rs, ifid_rt, idex_rd, idex_mem_rd, idex_reg_wr,
                         exmem_rd, exmem_mem_rd, exmem_reg_wr,
                         id_branch, id_br_ne, id_regs_equal})) begin
            a_r8_stall_beats_redirect: assert (!(idex_bubble && (if_flush || pc_sel_branch)))
                else $error("redirect during stall");
            a_r9_enables_agree: assert (pc_we == ifid_we && pc_we == !idex_bubble)
                else $error("front-end enables disagree");
            if (load_use_hit) begin
                a_r1_load_use_holds: assert (!pc_we && idex_bubble)
                    else $error("load-use not stalled");
            end
            if (!id_branch) begin
                a_r5_nonbranch_mem_free: assert (!br_mem_hit && !br_ex_hit)
                    else $error("non-branch held by branch dependence");
            end
        end
    end
endmodule

// File: tb/hazard_ctl_tb_top.sv
module hazard_ctl_tb_top;
    localparam int AW = 5;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic [AW-1:0] ifid_rs = '0, ifid_rt = '0, idex_rd = '0, exmem_rd = '0;
    logic idex_mem_rd = 0, idex_reg_wr = 0, exmem_mem_rd = 0, exmem_reg_wr = 0;
    logic id_branch = 0, id_br_ne = 0, id_regs_equal = 0;
    logic pc_we, ifid_we, idex_bubble, if_flush, pc_sel_branch;

    int checks = 0;
    int errors = 0;

    hazard_ctl #(.AW(AW)) dut_i (
        .ifid_rs(ifid_rs), .ifid_rt(ifid_rt), .idex_rd(idex_rd),
        .idex_mem_rd(idex_mem_rd), .idex_reg_wr(idex_reg_wr),
        .exmem_rd(exmem_rd), .exmem_mem_rd(exmem_mem_rd), .exmem_reg_wr(exmem_reg_wr),
        .id_branch(id_branch), .id_br_ne(id_br_ne), .id_regs_equal(id_regs_equal),
        .pc_we(pc_we), .ifid_we(ifid_we), .idex_bubble(idex_bubble),
        .if_flush(if_flush), .pc_sel_branch(pc_sel_branch)
    );

    function automatic logic uses(input logic [AW-1:0] d);
        return (d != 0) && (d == ifid_rs || d == ifid_rt);
    endfunction

    function automatic logic exp_stall();
        logic lu, bx, bm;
        lu = idex_mem_rd && uses(idex_rd);
        bx = id_branch && (idex_reg_wr || idex_mem_rd) && uses(idex_rd);
        bm = id_branch && exmem_mem_rd && exmem_reg_wr && uses(exmem_rd);
        return lu || bx || bm;
    endfunction

    // packed as {pc_we, ifid_we, idex_bubble, if_flush, pc_sel_branch}
    function automatic logic [4:0] exp_out();
        logic s, t;
        s = exp_stall();
        t = id_branch && (id_regs_equal ^ id_br_ne) && !s;
        return {!s, !s, s, t, t};
    endfunction

    function automatic string tag_of();
        if (idex_mem_rd && uses(idex_rd)) return "R1";
        if (id_branch && (idex_reg_wr || idex_mem_rd) && uses(idex_rd)) return "R4";
        if (id_branch && exmem_mem_rd && exmem_reg_wr && uses(exmem_rd)) return "R5";
        if (id_branch && (id_regs_equal ^ id_br_ne)) return "R6";
        return "R2";
    endfunction

    task automatic check(input string req);
        logic [4:0] act, exp;
        @(negedge clk);
        act = {pc_we, ifid_we, idex_bubble, if_flush, pc_sel_branch};
        exp = exp_out();
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: outputs %b expected %b", req, act, exp);
        end
        if (pc_we !== ifid_we || pc_we !== !idex_bubble) begin
            errors++;
            $display("FAIL R9: pc_we %b ifid_we %b bubble %b expected agreement",
                     pc_we, ifid_we, idex_bubble);
        end
        @(posedge clk);
        #1;
    endtask

    task automatic clear();
        ifid_rs = '0; ifid_rt = '0; idex_rd = '0; exmem_rd = '0;
        idex_mem_rd = 0; idex_reg_wr = 0; exmem_mem_rd = 0; exmem_reg_wr = 0;
        id_branch = 0; id_br_ne = 0; id_regs_equal = 0;
    endtask

    task automatic expect_bits(input string req, input logic [4:0] want);
        logic [4:0] act;
        @(negedge clk);
        act = {pc_we, ifid_we, idex_bubble, if_flush, pc_sel_branch};
        checks++;
        if (act !== want) begin
            errors++;
            $display("FAIL %s: outputs %b expected %b", req, act, want);
        end
        @(posedge clk);
        #1;
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        @(posedge clk); #1;

        // idle state
        clear();
        expect_bits("R2", 5'b11000);

        // R1: load r3, then add using r3 in either source slot
        clear(); idex_mem_rd = 1; idex_reg_wr = 1; idex_rd = 3; ifid_rs = 3; ifid_rt = 7;
        expect_bits("R1", 5'b00100);
        ifid_rs = 6; ifid_rt = 3;
        expect_bits("R1", 5'b00100);

        // R3: load into r0 read by r0 does not stall
        clear(); idex_mem_rd = 1; idex_reg_wr = 1; idex_rd = 0;
        id_branch = 1; id_regs_equal = 1;
        expect_bits("R3", 5'b11011);
        clear(); exmem_mem_rd = 1; exmem_reg_wr = 1; id_branch = 1;
        expect_bits("R3", 5'b11000);

        // R4: ALU result in execute blocks a branch, not a plain add
        clear(); idex_reg_wr = 1; idex_rd = 9; ifid_rs = 9; id_branch = 1; id_regs_equal = 1;
        expect_bits("R4", 5'b00100);
        id_branch = 0;
        expect_bits("R4", 5'b11000);

        // R5: load in memory stage blocks branch; ALU in memory stage does not
        clear(); exmem_mem_rd = 1; exmem_reg_wr = 1; exmem_rd = 4; ifid_rt = 4; id_branch = 1;
        expect_bits("R5", 5'b00100);
        exmem_mem_rd = 0;
        expect_bits("R5", 5'b11000);
        exmem_mem_rd = 1; id_branch = 0;
        expect_bits("R5", 5'b11000);

        // R6/R7: both branch senses
        clear(); id_branch = 1; id_regs_equal = 1;
        expect_bits("R6", 5'b11011);
        id_br_ne = 1;
        expect_bits("R7", 5'b11000);
        id_regs_equal = 0;
        expect_bits("R6", 5'b11011);
        id_branch = 0;
        expect_bits("R7", 5'b11000);

        // R8: taken branch with pending operand must not redirect
        clear(); idex_reg_wr = 1; idex_rd = 2; ifid_rs = 2; id_branch = 1; id_regs_equal = 1;
        expect_bits("R8", 5'b00100);

        // R10: load r5 then dependent branch, load advances one stage per cycle
        clear(); idex_mem_rd = 1; idex_reg_wr = 1; idex_rd = 5;
        ifid_rs = 5; id_branch = 1; id_regs_equal = 1;
        expect_bits("R10", 5'b00100);
        idex_mem_rd = 0; idex_reg_wr = 0; idex_rd = 0;
        exmem_mem_rd = 1; exmem_reg_wr = 1; exmem_rd = 5;
        expect_bits("R10", 5'b00100);
        exmem_mem_rd = 0; exmem_reg_wr = 0; exmem_rd = 0;
        expect_bits("R10", 5'b11011);

        // R10: load r5 then dependent add, one stall cycle only
        clear(); idex_mem_rd = 1; idex_reg_wr = 1; idex_rd = 5; ifid_rt = 5;
        expect_bits("R10", 5'b00100);
        idex_mem_rd = 0; idex_reg_wr = 0; idex_rd = 0;
        exmem_mem_rd = 1; exmem_reg_wr = 1; exmem_rd = 5;
        expect_bits("R10", 5'b11000);

        // random mix with a tiny register range to force matches
        for (int i = 0; i < 3000; i++) begin
            ifid_rs       = AW'($urandom_range(0, 3));
            ifid_rt       = AW'($urandom_range(0, 3));
            idex_rd       = AW'($urandom_range(0, 3));
            exmem_rd      = AW'($urandom_range(0, 3));
            idex_mem_rd   = 1'($urandom_range(0, 1));
            idex_reg_wr   = 1'($urandom_range(0, 1));
            exmem_mem_rd  = 1'($urandom_range(0, 1));
            exmem_reg_wr  = 1'($urandom_range(0, 1));
            id_branch     = 1'($urandom_range(0, 1));
            id_br_ne      = 1'($urandom_range(0, 1));
            id_regs_equal = 1'($urandom_range(0, 1));
            check(tag_of());
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule